// File: doc/BRIEF.md
# Hot Reset Sequencing Controller

This block orders the steps a multi-port switch goes through when it is hot reset. Three events can start a sequence: a training set arriving on the upstream port with its hot-reset flag set, the upstream data link layer dropping to its down state, or software setting a hot-reset control bit. A control input can mask the link-down event. It does not mask the other two. Once a sequence starts, the controller first asks every downstream port whose link is up to send hot-reset training sets. It then pulses the core logic reset, which clears all register fields except the sticky and lock-protected ones. Next it requests link training and holds the protocol stacks in a quasi-reset phase.

While the stacks are in quasi-reset, configuration requests are answered with a retry-status completion and all other requests are dropped. Two deadline timers, each counted in clock cycles, track how long training takes to become active and how long the stacks take to become ready. A flag is raised if either deadline passes. The stacks are released only after both handshakes are seen and the software halt bit is clear. If the operating mode needs it and the reload-disable bit is clear, the controller requests a serial EEPROM register reload and waits for the reload to finish before releasing the stacks. A trigger that arrives while a sequence is running is remembered and causes exactly one more sequence.

Top module: `hot_rst_seq`

## Requirements
- R1: `state_o` reports the phase with the encoding idle=0, propagate=1, core reset=2, train/quasi=3, eeprom load=4, run=5. From idle, the sequence starts on the clock edge that samples a rising edge of `ts1_hot_i` or of `dl_down_i`, or on the edge after the software bit is set. Reset leaves the block in idle with all outputs low.
- R2: When `ld_dis_i` is high, a rising edge of `dl_down_i` does not start a sequence. Triggers from `ts1_hot_i` and from software still work.
- R3: A pulse on `sw_hot_set_i` sets `sw_hot_bit_o`. The bit clears by itself on the edge that takes the sequencer out of idle.
- R4: In propagate, `ds_hot_tx_o` equals `ds_link_up_i`. Propagate lasts exactly PROP_CYC cycles. In every other state `ds_hot_tx_o` is zero.
- R5: Propagate is followed by core reset, where `core_rst_o` is high for exactly CORE_CYC cycles.
- R6: In train/quasi, `train_req_o` and `quasi_o` are high. The state is left only after training-active and stack-ready have each been seen at some point since the state was entered, and `halt_i` is low.
- R7: While `quasi_o` is high, a request with `req_is_cfg_i`=1 raises `rsp_retry_o` and any other request raises `req_drop_o`. In idle and run, requests raise `req_pass_o`. In propagate and core reset, requests are dropped.
- R8: `train_tmo_o` is set if training-active has not been seen within TRAIN_WIN cycles of entering train/quasi. `ready_tmo_o` is set the same way for stack-ready within READY_WIN cycles. Both flags hold until the next sequence starts.
- R9: On leaving train/quasi, the block enters eeprom load only if `mode_eep_i` is 1 and `eep_dis_i` is 0. Otherwise it goes straight to run. In eeprom load, `eeprom_req_o` stays high until `eeprom_done_i` is seen, and the block then goes to run.
- R10: Any number of triggers that arrive while a sequence is running cause exactly one further full sequence after the current one ends.
- R11: While `halt_i` is high, the block stays in train/quasi even with both handshakes seen. It leaves on the edge after `halt_i` falls.
- R12: Run lasts one cycle, with `stack_release_o` high, and the block then returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ts1_hot_i | input | 1 | Upstream training set with hot-reset flag received |
| dl_down_i | input | 1 | Upstream data link layer is down |
| sw_hot_set_i | input | 1 | Software write of 1 to the hot-reset bit |
| ld_dis_i | input | 1 | Mask for the link-down trigger |
| halt_i | input | 1 | Software halt: keep the stacks in quasi-reset |
| mode_eep_i | input | 1 | Operating mode needs EEPROM initialization |
| eep_dis_i | input | 1 | Disable EEPROM reload on hot reset |
| ds_link_up_i | input | NPORT | Link-up status of each downstream port |
| train_act_i | input | 1 | Link training is active |
| stack_rdy_i | input | 1 | Stacks can handle configuration requests |
| eeprom_done_i | input | 1 | EEPROM reload has finished |
| req_valid_i | input | 1 | Incoming transaction present |
| req_is_cfg_i | input | 1 | Incoming transaction is a configuration request |
| ds_hot_tx_o | output | NPORT | Per-port request to send hot-reset training sets |
| core_rst_o | output | 1 | Core logic reset (non-sticky fields) |
| train_req_o | output | 1 | Link training request |
| quasi_o | output | 1 | Stacks held in quasi-reset |
| eeprom_req_o | output | 1 | EEPROM register reload request |
| stack_release_o | output | 1 | Single-cycle release of the stacks |
| sw_hot_bit_o | output | 1 | Software hot-reset bit |
| train_tmo_o | output | 1 | Training-active deadline missed |
| ready_tmo_o | output | 1 | Stack-ready deadline missed |
| rsp_retry_o | output | 1 | Answer the current request with retry status |
| req_drop_o | output | 1 | Drop the current request |
| req_pass_o | output | 1 | Current request passes normally |
| state_o | output | 3 | Current phase (see R1) |

## Verification
The hardest case to reach from the ports is a trigger that arrives in the middle of a running sequence. To reach it, the stimulus fires a second training-set trigger while core reset is in progress. It then counts entries into propagate over the following window and checks that exactly one extra sequence runs, not zero and not two. The deadline flags are nearly as hard to reach, because the handshakes must be withheld across the whole window. The bench uses short windows and checks the flag one cycle before and on the exact cycle it is due.

// File: rtl/hrs_pkg.sv
package hrs_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_PROP = 3'd1,
    S_CORE = 3'd2,
    S_TQ   = 3'd3,
    S_EEP  = 3'd4,
    S_RUN  = 3'd5
  } hrs_state_e;
endpackage

// File: rtl/hrs_trigger.sv
module hrs_trigger (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ts1_hot_i,
  input  logic dl_down_i,
  input  logic sw_hot_set_i,
  input  logic ld_dis_i,
  input  logic idle_i,
  input  logic leave_idle_i,
  output logic start_o,
  output logic sw_bit_o
);
  logic ts1_q, dl_q, pend_q, sw_q;
  logic ev;

  assign ev = (ts1_hot_i & ~ts1_q) | (dl_down_i & ~dl_q & ~ld_dis_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ts1_q  <= 1'b0;
      dl_q   <= 1'b0;
      pend_q <= 1'b0;
      sw_q   <= 1'b0;
    end else begin
      ts1_q <= ts1_hot_i;
      dl_q  <= dl_down_i;
      // events seen while busy are remembered for one more pass
      if (!idle_i && ev)     pend_q <= 1'b1;
      else if (leave_idle_i) pend_q <= 1'b0;
      if (sw_hot_set_i)      sw_q <= 1'b1;
      else if (leave_idle_i) sw_q <= 1'b0;
    end
  end

  assign start_o  = ev | sw_q | pend_q;
  assign sw_bit_o = sw_q;

  p_sw_selfclr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (leave_idle_i && !sw_hot_set_i) |=> !sw_bit_o);
  p_dl_mask_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_i && ld_dis_i && !sw_q && !pend_q && !ts1_hot_i) |-> !leave_idle_i);
endmodule

// File: rtl/hrs_deadline.sv
module hrs_deadline #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic run_i,
  input  logic seen_i,
  output logic done_o,
  output logic tmo_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
  localparam logic [CW-1:0] MAXV = CW'(LIMIT);

  logic [CW-1:0] cnt_q;
  logic          seen_q, tmo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
      tmo_q  <= 1'b0;
    end else if (arm_i) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
      tmo_q  <= 1'b0;
    end else if (run_i) begin
      if (cnt_q != MAXV) cnt_q <= cnt_q + 1'b1;
      if (seen_i) seen_q <= 1'b1;
      if (!done_o && cnt_q == LAST) tmo_q <= 1'b1;
    end
  end

  assign done_o = seen_q | seen_i;
  assign tmo_o  = tmo_q;

  p_tmo_unseen_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tmo_o) |-> !$past(done_o));
  p_tmo_late_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o |-> cnt_q == MAXV);
endmodule

// File: rtl/hot_rst_seq.sv
module hot_rst_seq
  import hrs_pkg::*;
#(
  parameter int unsigned NPORT     = 3,
  parameter int unsigned PROP_CYC  = 4,
  parameter int unsigned CORE_CYC  = 8,
  parameter int unsigned TRAIN_WIN = 2500000,
  parameter int unsigned READY_WIN = 12500000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ts1_hot_i,
  input  logic             dl_down_i,
  input  logic             sw_hot_set_i,
  input  logic             ld_dis_i,
  input  logic             halt_i,
  input  logic             mode_eep_i,
  input  logic             eep_dis_i,
  input  logic [NPORT-1:0] ds_link_up_i,
  input  logic             train_act_i,
  input  logic             stack_rdy_i,
  input  logic             eeprom_done_i,
  input  logic             req_valid_i,
  input  logic             req_is_cfg_i,
  output logic [NPORT-1:0] ds_hot_tx_o,
  output logic             core_rst_o,
  output logic             train_req_o,
  output logic             quasi_o,
  output logic             eeprom_req_o,
  output logic             stack_release_o,
  output logic             sw_hot_bit_o,
  output logic             train_tmo_o,
  output logic             ready_tmo_o,
  output logic             rsp_retry_o,
  output logic             req_drop_o,
  output logic             req_pass_o,
  output logic [2:0]       state_o
);
  localparam int unsigned PMAX = (PROP_CYC > CORE_CYC) ? PROP_CYC : CORE_CYC;
  localparam int unsigned PW   = $clog2(PMAX + 1);
  localparam logic [PW-1:0] PROP_LAST = PW'(PROP_CYC - 1);
  localparam logic [PW-1:0] CORE_LAST = PW'(CORE_CYC - 1);

  hrs_state_e    state_q, state_d;
  logic [PW-1:0] ph_q;
  logic          start, idle, leave_idle, t_done, r_done, in_tq, need_eep, open_st;

  assign idle       = (state_q == S_IDLE);
  assign leave_idle = idle & start;
  assign in_tq      = (state_q == S_TQ);
  assign need_eep   = mode_eep_i & ~eep_dis_i;

  hrs_trigger u_trig (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ts1_hot_i    (ts1_hot_i),
    .dl_down_i    (dl_down_i),
    .sw_hot_set_i (sw_hot_set_i),
    .ld_dis_i     (ld_dis_i),
    .idle_i       (idle),
    .leave_idle_i (leave_idle),
    .start_o      (start),
    .sw_bit_o     (sw_hot_bit_o)
  );

  hrs_deadline #(.LIMIT(TRAIN_WIN)) u_train_dl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (leave_idle),
    .run_i  (in_tq),
    .seen_i (train_act_i),
    .done_o (t_done),
    .tmo_o  (train_tmo_o)
  );

  hrs_deadline #(.LIMIT(READY_WIN)) u_ready_dl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .arm_i  (leave_idle),
    .run_i  (in_tq),
    .seen_i (stack_rdy_i),
    .done_o (r_done),
    .tmo_o  (ready_tmo_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (start) state_d = S_PROP;
      S_PROP: if (ph_q == PROP_LAST) state_d = S_CORE;
      S_CORE: if (ph_q == CORE_LAST) state_d = S_TQ;
      S_TQ:   if (t_done && r_done && !halt_i) state_d = need_eep ? S_EEP : S_RUN;
      S_EEP:  if (eeprom_done_i) state_d = S_RUN;
      S_RUN:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      ph_q    <= '0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q) ph_q <= '0;
      else if (state_q == S_PROP || state_q == S_CORE) ph_q <= ph_q + 1'b1;
    end
  end

  assign open_st         = idle | (state_q == S_RUN);
  assign ds_hot_tx_o     = (state_q == S_PROP) ? ds_link_up_i : '0;
  assign core_rst_o      = (state_q == S_CORE);
  assign train_req_o     = in_tq;
  assign quasi_o         = in_tq | (state_q == S_EEP);
  assign eeprom_req_o    = (state_q == S_EEP);
  assign stack_release_o = (state_q == S_RUN);
  assign rsp_retry_o     = req_valid_i & quasi_o & req_is_cfg_i;
  assign req_drop_o      = req_valid_i & ~open_st & ~(quasi_o & req_is_cfg_i);
  assign req_pass_o      = req_valid_i & open_st;
  assign state_o         = state_q;

  p_prop_from_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_PROP && $past(state_q) != S_PROP) |-> $past(state_q) == S_IDLE);
  p_core_after_prop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_rst_o) |-> $past(state_q) == S_PROP);
  p_tq_exit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state_q) == S_TQ && state_q != S_TQ) |-> $past(t_done && r_done && !halt_i));
  p_eep_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eeprom_req_o) |-> $past(mode_eep_i && !eep_dis_i));
  p_release_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stack_release_o |=> state_q == S_IDLE);
  p_tx_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_rst_o |-> ds_hot_tx_o == '0);
endmodule

// File: tb/test_hot_rst_seq.sv
module test_hot_rst_seq;
  localparam int NP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ts1 = 0, dl = 0, sw_set = 0, ld_dis = 0, halt = 0, mode = 0, edis = 0;
  logic [NP-1:0] lnk = 3'b101;
  logic tact = 1, srdy = 1, edone = 0, rv = 0, rcfg = 0;
  logic [NP-1:0] hot_tx;
  logic core_rst, treq, quasi, ereq, rel, swbit, ttmo, rtmo, retry, drop, pass;
  logic [2:0] st;
  int n_chk = 0, n_bad = 0;
  bit fin = 0;

  always #4 clk = ~clk;

  hot_rst_seq #(.NPORT(NP), .PROP_CYC(4), .CORE_CYC(8), .TRAIN_WIN(20), .READY_WIN(40)) i_hot_rst_seq (
    .clk_i(clk), .rst_ni(rst_n), .ts1_hot_i(ts1), .dl_down_i(dl), .sw_hot_set_i(sw_set),
    .ld_dis_i(ld_dis), .halt_i(halt), .mode_eep_i(mode), .eep_dis_i(edis),
    .ds_link_up_i(lnk), .train_act_i(tact), .stack_rdy_i(srdy), .eeprom_done_i(edone),
    .req_valid_i(rv), .req_is_cfg_i(rcfg), .ds_hot_tx_o(hot_tx), .core_rst_o(core_rst),
    .train_req_o(treq), .quasi_o(quasi), .eeprom_req_o(ereq), .stack_release_o(rel),
    .sw_hot_bit_o(swbit), .train_tmo_o(ttmo), .ready_tmo_o(rtmo), .rsp_retry_o(retry),
    .req_drop_o(drop), .req_pass_o(pass), .state_o(st));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_st(input int s, input string req);
    int n = 0;
    while (int'(st) != s && n < 300) begin
      @(negedge clk);
      n++;
    end
    chk(req, int'(st), s);
  endtask

  task automatic pulse_ts1();
    @(negedge clk); ts1 = 1;
    @(negedge clk); ts1 = 0;
  endtask

  task automatic t_reset();
    chk("R1 reset state", st, 0);
    chk("R1 reset outputs", {hot_tx, core_rst, treq, quasi, ereq, rel, swbit, ttmo, rtmo}, 0);
  endtask

  task automatic t_main();
    int n;
    srdy = 0;
    pulse_ts1();
    chk("R1 ts1 start", st, 1);
    chk("R4 tx mask", hot_tx, 5);
    n = 1;
    while (st == 1 && n < 50) begin step(1); n++; end
    chk("R4 prop length", n - 1, 4);
    chk("R5 core entry", st, 2);
    chk("R4 tx idle in core", hot_tx, 0);
    n = 0;
    while (st == 2 && n < 50) begin
      if (!core_rst) chk("R5 core_rst high", core_rst, 1);
      step(1); n++;
    end
    chk("R5 core length", n, 8);
    chk("R6 tq entry", st, 3);
    chk("R6 train/quasi", {treq, quasi}, 3);
    rv = 1; rcfg = 1; #1;
    chk("R7 cfg retry", {retry, drop, pass}, 4);
    rcfg = 0; #1;
    chk("R7 other dropped", {retry, drop, pass}, 2);
    rv = 0;
    step(3);
    chk("R6 waits for ready", st, 3);
    srdy = 1;
    step(1);
    chk("R12 run", {3'(st), rel}, {3'd5, 1'b1});
    step(1);
    chk("R12 back to idle", st, 0);
    rv = 1; #1;
    chk("R7 pass in idle", {retry, drop, pass}, 1);
    rv = 0;
  endtask

  task automatic t_prop_drop();
    pulse_ts1();
    rv = 1; rcfg = 1; #1;
    chk("R7 drop in propagate", {retry, drop, pass}, 2);
    rv = 0; rcfg = 0;
    wait_st(0, "R12 idle after seq");
  endtask

  task automatic t_dis();
    @(negedge clk); ld_dis = 1; dl = 1;
    step(3);
    chk("R2 masked dl", st, 0);
    dl = 0; sw_set = 1;
    step(1); sw_set = 0;
    chk("R3 sw bit set", {swbit, 3'(st)}, {1'b1, 3'd0});
    step(1);
    chk("R2 sw works masked", st, 1);
    chk("R3 sw self clear", swbit, 0);
    wait_st(0, "R12 idle");
    pulse_ts1();
    chk("R2 ts1 works masked", st, 1);
    wait_st(0, "R12 idle");
    ld_dis = 0; dl = 1;
    step(1);
    chk("R1 dl start", st, 1);
    dl = 0;
    wait_st(0, "R12 idle");
  endtask

  task automatic t_tmo();
    tact = 0; srdy = 0;
    pulse_ts1();
    wait_st(3, "R8 reach tq");
    step(19);
    chk("R8 no early tmo", ttmo, 0);
    step(1);
    chk("R8 train tmo due", ttmo, 1);
    chk("R8 ready not yet", rtmo, 0);
    tact = 1; srdy = 1;
    step(1);
    chk("R8 exit after tmo", st, 5);
    chk("R8 ready kept clear", rtmo, 0);
    chk("R8 train tmo held", ttmo, 1);
    wait_st(0, "R12 idle");
    pulse_ts1();
    chk("R8 flag cleared on start", ttmo, 0);
    wait_st(0, "R12 idle");
  endtask

  task automatic t_halt();
    halt = 1;
    pulse_ts1();
    wait_st(3, "R11 reach tq");
    step(5);
    chk("R11 held", st, 3);
    halt = 0;
    step(1);
    chk("R11 release", st, 5);
    wait_st(0, "R12 idle");
  endtask

  task automatic t_eep();
    mode = 1; edis = 0;
    pulse_ts1();
    wait_st(3, "R9 reach tq");
    step(1);
    chk("R9 eeprom state", {3'(st), ereq, quasi}, {3'd4, 1'b1, 1'b1});
    step(4);
    chk("R9 waits done", st, 4);
    edone = 1;
    step(1);
    edone = 0;
    chk("R9 done to run", st, 5);
    wait_st(0, "R12 idle");
    edis = 1;
    pulse_ts1();
    wait_st(3, "R9 reach tq");
    step(1);
    chk("R9 disabled skip", {3'(st), ereq}, {3'd5, 1'b0});
    wait_st(0, "R12 idle");
    mode = 0;
    pulse_ts1();
    wait_st(3, "R9 reach tq");
    step(1);
    chk("R9 mode skip", st, 5);
    mode = 0; edis = 0;
    wait_st(0, "R12 idle");
  endtask

  task automatic t_pend();
    int ent = 0;
    logic [2:0] prev;
    pulse_ts1();
    wait_st(2, "R10 reach core");
    pulse_ts1();
    pulse_ts1();
    wait_st(5, "R10 reach run");
    prev = st;
    for (int i = 0; i < 120; i++) begin
      step(1);
      if (st == 1 && prev != 1) ent++;
      prev = st;
    end
    chk("R10 one extra seq", ent, 1);
    chk("R10 settles idle", st, 0);
  endtask

  initial begin
    step(3);
    t_reset();
    @(negedge clk); rst_n = 1;
    step(2);
    t_main();
    t_prop_drop();
    t_dis();
    t_tmo();
    t_halt();
    t_eep();
    t_pend();
    fin = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule